// File: doc/BRIEF.md
# Two-Lane Shift-Mask-Add Interpolator

This block is a register-mapped arithmetic helper. It holds two accumulators, three base registers and two lane configuration words. Each lane takes its accumulator, shifts it right, keeps a chosen bit field, can sign-extend that field, and adds the lane's base. A combined result adds both lane fields to the third base. Software walks tables or texture coordinates by reading results and updating the accumulators in the same access.

All accesses use one address per cycle with separate write and read enables. Read data is combinational from the current state. Reads of the result addresses come in two kinds. A peek only observes. A pop also loads each lane result back into its own accumulator at the next clock edge. Writes can load a register directly or add into an accumulator. A packed write loads both lane bases from one word, with each half widened according to its lane's signed flag.

Top module: `interp_unit`

## Requirements
- R1: After reset all accumulators, bases and lane configurations are zero, and every read address returns 0. With `rdEn` low, `rdData` is 0.
- R2: Writes to addresses 0 and 1 (accumulators 0 and 1), 2, 3 and 4 (bases 0, 1 and 2), and 5 and 6 (lane 0 and lane 1 configuration) take effect at the next clock edge. A read of the same address returns the stored value. Configuration reads return the 16 stored bits, zero-extended.
- R3: The lane configuration word holds the shift amount in bits [4:0], the field low bit in [9:5], the field high bit in [14:10] and the signed flag in bit 15. A lane's raw value is its accumulator shifted right logically by the shift amount, with every bit outside low..high cleared.
- R4: When the signed flag is set and bit `high` of the raw field is 1, every bit above `high` in the raw value is set to 1.
- R5: A lane result is its base plus its raw value. Address 10 reads lane 0, address 11 reads lane 1, and address 12 reads base 2 plus both raw values, all modulo 2^32.
- R6: Writing address 7 (or 8) adds the write data to accumulator 0 (or 1) modulo 2^32 at the next edge.
- R7: Reading address 7 (or 8) returns lane 0's (or lane 1's) raw value with no base added, and changes nothing.
- R8: Writing address 9 loads bits [15:0] into base 0 and bits [31:16] into base 1 in the same edge. Each half is sign-extended when its lane's signed flag is set and zero-extended otherwise. Reading address 9 returns 0.
- R9: Reads of addresses 10 to 12 leave all state unchanged.
- R10: Addresses 13, 14 and 15 return the same values as 10, 11 and 12. At the next edge they load lane 0's result into accumulator 0 and lane 1's result into accumulator 1, with both results computed from the pre-edge state.
- R11: Writes to addresses 10 to 15 have no effect on any state.
- R12: When the field low bit is greater than the high bit, the raw value is 0 whatever the signed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for `addr` |
| rdEn | input | 1 | Read strobe for `addr`; a pop takes effect only when this is set |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |

## Verification
The hardest case to reach is a pop issued while the accumulators hold values that drive fields near the word edge. These are shifts that run bits off the top, fields whose high bit is set and signed, and empty fields with low above high. In that case the write-back must use the pre-edge results while the added base wraps. The bench reaches it with a long stretch of random accesses over all sixteen addresses. About one configuration write in four in that stretch has an inverted field, and pops are interleaved with adds and packed writes. Every read is compared against a bit-by-bit model kept in the bench.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = DATA_W / 2;
  localparam int SHIFT_W   = $clog2(DATA_W);
  localparam int CTRL_W    = 3 * SHIFT_W + 1;
  localparam int NUM_LANES = 2;
  localparam int NUM_BASES = NUM_LANES + 1;
  localparam int ADDR_W    = 4;
  localparam int IDX_W     = $clog2(NUM_BASES);

  typedef enum logic [ADDR_W-1:0] {
    A_ACC0   = 4'd0,  A_ACC1   = 4'd1,
    A_BASE0  = 4'd2,  A_BASE1  = 4'd3,  A_BASE2 = 4'd4,
    A_CFG0   = 4'd5,  A_CFG1   = 4'd6,
    A_ADD0   = 4'd7,  A_ADD1   = 4'd8,  A_PACK  = 4'd9,
    A_PEEK0  = 4'd10, A_PEEK1  = 4'd11, A_PEEKF = 4'd12,
    A_POP0   = 4'd13, A_POP1   = 4'd14, A_POPF  = 4'd15
  } regAddr_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ACC, SEL_BASE, SEL_CFG, SEL_RAW, SEL_LANE, SEL_FULL
  } rdSel_e;

  typedef struct packed {
    logic               sgn;
    logic [SHIFT_W-1:0] hiBit;
    logic [SHIFT_W-1:0] loBit;
    logic [SHIFT_W-1:0] shift;
  } laneCfg_t;

  typedef struct packed {
    logic [NUM_LANES-1:0] wrAcc;
    logic [NUM_LANES-1:0] addAcc;
    logic [NUM_BASES-1:0] wrBase;
    logic [NUM_LANES-1:0] wrCfg;
    logic                 wrPack;
    logic                 pop;
    logic                 peek;
  } strobe_t;

  function automatic logic [DATA_W-1:0] widenHalf(input logic [HALF_W-1:0] h,
                                                  input logic sgn);
    return sgn ? {{HALF_W{h[HALF_W-1]}}, h} : {{HALF_W{1'b0}}, h};
  endfunction
endpackage

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import interp_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output rdSel_e            rdSel,
  output logic [IDX_W-1:0]  rdIdx
);
  always_comb begin
    stb   = '0;
    rdSel = SEL_ZERO;
    rdIdx = '0;
    if (wrEn) begin
      case (addr)
        A_ACC0:  stb.wrAcc[0]  = 1'b1;
        A_ACC1:  stb.wrAcc[1]  = 1'b1;
        A_BASE0: stb.wrBase[0] = 1'b1;
        A_BASE1: stb.wrBase[1] = 1'b1;
        A_BASE2: stb.wrBase[2] = 1'b1;
        A_CFG0:  stb.wrCfg[0]  = 1'b1;
        A_CFG1:  stb.wrCfg[1]  = 1'b1;
        A_ADD0:  stb.addAcc[0] = 1'b1;
        A_ADD1:  stb.addAcc[1] = 1'b1;
        A_PACK:  stb.wrPack    = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (addr)
        A_ACC0:  begin rdSel = SEL_ACC;  rdIdx = 2'd0; end
        A_ACC1:  begin rdSel = SEL_ACC;  rdIdx = 2'd1; end
        A_BASE0: begin rdSel = SEL_BASE; rdIdx = 2'd0; end
        A_BASE1: begin rdSel = SEL_BASE; rdIdx = 2'd1; end
        A_BASE2: begin rdSel = SEL_BASE; rdIdx = 2'd2; end
        A_CFG0:  begin rdSel = SEL_CFG;  rdIdx = 2'd0; end
        A_CFG1:  begin rdSel = SEL_CFG;  rdIdx = 2'd1; end
        A_ADD0:  begin rdSel = SEL_RAW;  rdIdx = 2'd0; end
        A_ADD1:  begin rdSel = SEL_RAW;  rdIdx = 2'd1; end
        A_PEEK0: begin rdSel = SEL_LANE; rdIdx = 2'd0; stb.peek = 1'b1; end
        A_PEEK1: begin rdSel = SEL_LANE; rdIdx = 2'd1; stb.peek = 1'b1; end
        A_PEEKF: begin rdSel = SEL_FULL;               stb.peek = 1'b1; end
        A_POP0:  begin rdSel = SEL_LANE; rdIdx = 2'd0; stb.pop  = 1'b1; end
        A_POP1:  begin rdSel = SEL_LANE; rdIdx = 2'd1; stb.pop  = 1'b1; end
        A_POPF:  begin rdSel = SEL_FULL;               stb.pop  = 1'b1; end
        default: rdSel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
(
  input  logic [DATA_W-1:0] acc,
  input  laneCfg_t          cfg,
  output logic [DATA_W-1:0] raw
);
  localparam logic [SHIFT_W-1:0] TOP_IDX = SHIFT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] loMask;
  logic [DATA_W-1:0] hiMask;
  logic [DATA_W-1:0] field;

  always_comb begin
    shifted = acc >> cfg.shift;
    loMask  = {DATA_W{1'b1}} << cfg.loBit;
    hiMask  = {DATA_W{1'b1}} >> (TOP_IDX - cfg.hiBit);
    field   = shifted & loMask & hiMask;
    raw     = (cfg.sgn && field[cfg.hiBit]) ? (field | ~hiMask) : field;
  end
endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import interp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  rdSel_e            rdSel,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_LANES-1:0][DATA_W-1:0] accQ;
  logic [NUM_BASES-1:0][DATA_W-1:0] baseQ;
  logic [NUM_LANES-1:0][CTRL_W-1:0] cfgQ;
  logic [NUM_LANES-1:0][DATA_W-1:0] laneRaw;
  logic [NUM_LANES-1:0][DATA_W-1:0] laneRes;
  logic [DATA_W-1:0]                fullRes;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    laneCfg_t cfg;
    assign cfg = laneCfg_t'(cfgQ[g]);

    interp_lane uLane (
      .acc (accQ[g]),
      .cfg (cfg),
      .raw (laneRaw[g])
    );

    assign laneRes[g] = baseQ[g] + laneRaw[g];

    always_ff @(posedge clk) begin
      if (!rstN)               accQ[g] <= '0;
      else if (stb.pop)        accQ[g] <= laneRes[g];
      else if (stb.wrAcc[g])   accQ[g] <= wrData;
      else if (stb.addAcc[g])  accQ[g] <= accQ[g] + wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)               baseQ[g] <= '0;
      else if (stb.wrBase[g])  baseQ[g] <= wrData;
      else if (stb.wrPack)     baseQ[g] <= widenHalf(wrData[g*HALF_W +: HALF_W], cfg.sgn);
    end

    always_ff @(posedge clk) begin
      if (!rstN)               cfgQ[g] <= '0;
      else if (stb.wrCfg[g])   cfgQ[g] <= wrData[CTRL_W-1:0];
    end

    // R6
    acc_add_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.addAcc[g] |=> accQ[g] == $past(accQ[g] + wrData));

    // R10
    pop_writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.pop |=> accQ[g] == $past(laneRes[g]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                baseQ[NUM_BASES-1] <= '0;
    else if (stb.wrBase[NUM_BASES-1]) baseQ[NUM_BASES-1] <= wrData;
  end

  assign fullRes = baseQ[NUM_BASES-1] + laneRaw[0] + laneRaw[1];

  always_comb begin
    case (rdSel)
      SEL_ACC:  rdData = rdIdx[0] ? accQ[1] : accQ[0];
      SEL_BASE: rdData = (rdIdx == 2'd2) ? baseQ[2] : (rdIdx[0] ? baseQ[1] : baseQ[0]);
      SEL_CFG:  rdData = {{(DATA_W-CTRL_W){1'b0}}, (rdIdx[0] ? cfgQ[1] : cfgQ[0])};
      SEL_RAW:  rdData = rdIdx[0] ? laneRaw[1] : laneRaw[0];
      SEL_LANE: rdData = rdIdx[0] ? laneRes[1] : laneRes[0];
      SEL_FULL: rdData = fullRes;
      default:  rdData = '0;
    endcase
  end

  // R9
  peek_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.peek |=> $stable(accQ) && $stable(baseQ) && $stable(cfgQ));

  // R8
  pack_halves_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrPack |=> baseQ[0][HALF_W-1:0] == $past(wrData[HALF_W-1:0]) &&
                   baseQ[1][HALF_W-1:0] == $past(wrData[DATA_W-1:HALF_W]));
endmodule

// File: rtl/interp_unit.sv
module interp_unit
  import interp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  strobe_t          stb;
  rdSel_e           rdSel;
  logic [IDX_W-1:0] rdIdx;

  interp_ctrl uCtrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel),
    .rdIdx (rdIdx)
  );

  interp_datapath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .rdIdx  (rdIdx),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_interp_unit.sv
module tb_interp_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mAcc [2];
  logic [31:0] mBase [3];
  logic [15:0] mCfg [2];

  interp_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] mkCfg(int sh, int lo, int hi, bit sg);
    return {sg, 5'(hi), 5'(lo), 5'(sh)};
  endfunction

  function automatic logic [31:0] mRaw(int n);
    logic [31:0] r = '0;
    int sh = mCfg[n][4:0];
    int lo = mCfg[n][9:5];
    int hi = mCfg[n][14:10];
    for (int b = 0; b < 32; b++)
      if (b >= lo && b <= hi && b + sh < 32) r[b] = mAcc[n][b + sh];
    if (mCfg[n][15] && r[hi])
      for (int b = hi + 1; b < 32; b++) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] mExpect(bit rd, int a);
    if (!rd) return 32'h0;
    case (a)
      0, 1:     return mAcc[a];
      2, 3, 4:  return mBase[a - 2];
      5, 6:     return {16'h0, mCfg[a - 5]};
      7, 8:     return mRaw(a - 7);
      9:        return 32'h0;
      10, 13:   return mBase[0] + mRaw(0);
      11, 14:   return mBase[1] + mRaw(1);
      default:  return mBase[2] + mRaw(0) + mRaw(1);
    endcase
  endfunction

  function automatic string reqOf(int a);
    if (a <= 6) return "R2";
    if (a <= 8) return "R7";
    if (a == 9) return "R8";
    if (a <= 12) return "R5";
    return "R10";
  endfunction

  function automatic logic [31:0] ext16(logic [15:0] h, bit sg);
    return sg ? {{16{h[15]}}, h} : {16'h0, h};
  endfunction

  task automatic cycle(bit w, bit r, int a, logic [31:0] d, string tag);
    logic [31:0] exp;
    logic [31:0] l0, l1;
    @(negedge clk);
    wrEn = w; rdEn = r; addr = 4'(a); wrData = d;
    #1;
    exp = mExpect(r, a);
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d got=%h exp=%h", tag, a, rdData, exp);
    end
    @(posedge clk);
    l0 = mBase[0] + mRaw(0);
    l1 = mBase[1] + mRaw(1);
    if (r && a >= 13) begin
      mAcc[0] = l0;
      mAcc[1] = l1;
    end
    if (w) begin
      case (a)
        0, 1:    mAcc[a] = d;
        2, 3, 4: mBase[a - 2] = d;
        5, 6:    mCfg[a - 5] = d[15:0];
        7, 8:    mAcc[a - 7] = mAcc[a - 7] + d;
        9: begin
          mBase[0] = ext16(d[15:0], mCfg[0][15]);
          mBase[1] = ext16(d[31:16], mCfg[1][15]);
        end
        default: ;
      endcase
    end
  endtask

  task automatic wr(int a, logic [31:0] d); cycle(1, 0, a, d, "R2"); endtask
  task automatic rd(int a, string tag); cycle(0, 1, a, 32'h0, tag); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mAcc[i] = '0; mCfg[i] = '0; end
    for (int i = 0; i < 3; i++) mBase[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state on every address, and idle read data
    for (int a = 0; a < 16; a++) rd(a, "R1");
    cycle(0, 0, 10, 32'h0, "R1");

    // R2: direct loads and readback
    wr(0, 32'h1234_5678); wr(1, 32'h0000_0F80);
    wr(2, 32'h0000_0100); wr(3, 32'h1000_0000); wr(4, 32'h0200_0000);
    wr(5, 32'hFFFF_0000 | 32'(mkCfg(4, 0, 7, 0)));
    wr(6, 32'(mkCfg(0, 4, 11, 1)));
    for (int a = 0; a < 7; a++) rd(a, "R2");

    // R3: shift and mask fields
    rd(7, "R3");
    wr(5, 32'(mkCfg(31, 0, 31, 0))); rd(7, "R3");
    wr(5, 32'(mkCfg(8, 3, 20, 0)));  rd(7, "R3");
    // R4: signed extension from the field high bit
    rd(8, "R4"); rd(11, "R4");
    wr(1, 32'h0000_0780); rd(8, "R4");
    // R12: inverted field gives zero
    wr(5, 32'(mkCfg(0, 9, 3, 1))); rd(7, "R12"); rd(10, "R12");
    wr(5, 32'(mkCfg(4, 0, 7, 0)));
    // R5: lane and full results
    rd(10, "R5"); rd(11, "R5"); rd(12, "R5");
    // R6: atomic add, with wrap
    cycle(1, 0, 7, 32'h0000_0011, "R6"); rd(0, "R6");
    wr(1, 32'hFFFF_FFF0);
    cycle(1, 0, 8, 32'h0000_0020, "R6"); rd(1, "R6");
    // R8: packed base write per-lane extension
    wr(5, 32'(mkCfg(0, 0, 31, 1))); wr(6, 32'(mkCfg(0, 0, 31, 0)));
    cycle(1, 0, 9, 32'h8001_9234, "R8"); rd(2, "R8"); rd(3, "R8"); rd(9, "R8");
    wr(5, 32'(mkCfg(0, 0, 31, 0))); wr(6, 32'(mkCfg(0, 0, 31, 1)));
    cycle(1, 0, 9, 32'h8001_9234, "R8"); rd(2, "R8"); rd(3, "R8");
    // R9: peeks leave state alone
    wr(5, 32'(mkCfg(2, 0, 15, 0))); wr(6, 32'(mkCfg(1, 2, 30, 1)));
    rd(10, "R9"); rd(11, "R9"); rd(12, "R9"); rd(12, "R9");
    rd(0, "R9"); rd(1, "R9");
    // R10: pops return pre-update results and write back
    rd(15, "R10"); rd(0, "R10"); rd(1, "R10");
    rd(13, "R10"); rd(13, "R10"); rd(14, "R10"); rd(0, "R10"); rd(1, "R10");
    // R11: writes to result addresses are ignored
    for (int a = 10; a < 16; a++) cycle(1, 0, a, 32'hDEAD_BEEF, "R11");
    for (int a = 0; a < 7; a++) rd(a, "R11");

    // random mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int a = $urandom_range(0, 15);
      bit w = 1'($urandom_range(0, 1));
      bit r = 1'($urandom_range(0, 1));
      logic [31:0] d = $urandom;
      if ((a == 5 || a == 6) && $urandom_range(0, 3) == 0)
        d = 32'(mkCfg($urandom_range(0, 31), $urandom_range(16, 31),
                      $urandom_range(0, 15), 1'($urandom_range(0, 1))));
      cycle(w, r, a, d, reqOf(a));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule